// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits on a byte-wide register bus next to a small processor and turns guarded erase commands into start requests for an on-chip flash controller. Software first writes a setup register and then, in the very next bus write, writes a specific byte pattern to a write-only command register. Only that exact pair produces an erase request.

A page erase is armed by writing the page-address register. A mass erase is armed by writing the mass-erase enable register, and it also needs the debug port to be enabled. Any other bus write, any issued command, or any command written while the flash controller reports busy clears both arm flags. An accepted command produces a start pulse one clock long. The page number stays on a dedicated output for the flash controller to use.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the page register and the enable register read 0x00, and neither start output is high.
- R2: A write to address 0xB7 stores bits 6:0 of the data as the page number. A read of 0xB7 returns that value with bit 7 at zero, and `erase_page` shows it.
- R3: Writing 0x55 to address 0x94 in the bus write directly after a write to 0xB7 raises `page_erase_start` in the clock cycle after the command write. `erase_page` then carries the stored page.
- R4: A 0x55 command that is not directly preceded by a write to 0xB7 produces no pulse. This covers a command with no setup write at all and a command with another write in between.
- R5: Writing 0xAA to 0x94 directly after a write to 0xB2 while `dbg_en` is high raises `mass_erase_start` in the clock cycle after the command write.
- R6: A 0xAA command produces no pulse if `dbg_en` is low or if the write just before it was not to 0xB2.
- R7: Any command byte other than 0x55 and 0xAA starts nothing and clears both arm flags.
- R8: A command written while `flash_busy` is high starts nothing and clears both arm flags.
- R9: A read of 0x94 returns 0x00. A read of 0xB2 returns bit 0 of the last value written there in bit 0 and zeros in the other bits. A read of any other address returns 0x00.
- R10: Each start pulse lasts exactly one cycle, and the two start outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Bus write strobe, one cycle per write |
| reg_rd | input | 1 | Bus read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, zero when no read |
| dbg_en | input | 1 | Debug port enabled status |
| flash_busy | input | 1 | Flash controller busy |
| page_erase_start | output | 1 | One-cycle page-erase request |
| mass_erase_start | output | 1 | One-cycle mass-erase request |
| erase_page | output | 7 | Page number for page erase |

## Verification
The assertions assume that `reg_wr`, `reg_addr` and `reg_wdata` are known and stable at each rising edge after reset, and that a write strobe counts as one write for each cycle it is high. The checks that look back one cycle, from a pulse to the command write before it, only hold if the bus inputs are not changed around the edge. The stimulus therefore changes every input on the falling edge and holds each write for exactly one cycle. The bench also keeps `dbg_en` and `flash_busy` constant across each setup/command pair, so the cycle in which each check looks is never in doubt.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter int          PW        = 7,
  parameter logic [7:0]  CMD_ADDR  = 8'h94,
  parameter logic [7:0]  PAGE_ADDR = 8'hB7,
  parameter logic [7:0]  MEEN_ADDR = 8'hB2,
  parameter logic [7:0]  PAGE_KEY  = 8'h55,
  parameter logic [7:0]  MASS_KEY  = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dbg_en,
  input  logic          flash_busy,
  output logic          page_erase_start,
  output logic          mass_erase_start,
  output logic [PW-1:0] erase_page
);

  localparam int PAD = DW - PW;

  logic [PW-1:0] page_q;
  logic          meen_q;
  logic          arm_pg, arm_me;

  wire wr_cmd  = reg_wr && (reg_addr == AW'(CMD_ADDR));
  wire wr_page = reg_wr && (reg_addr == AW'(PAGE_ADDR));
  wire wr_meen = reg_wr && (reg_addr == AW'(MEEN_ADDR));
  wire go_page = wr_cmd && !flash_busy && arm_pg && (reg_wdata == DW'(PAGE_KEY));
  wire go_mass = wr_cmd && !flash_busy && arm_me && dbg_en && (reg_wdata == DW'(MASS_KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q           <= '0;
      meen_q           <= 1'b0;
      arm_pg           <= 1'b0;
      arm_me           <= 1'b0;
      page_erase_start <= 1'b0;
      mass_erase_start <= 1'b0;
    end else begin
      page_erase_start <= go_page;
      mass_erase_start <= go_mass;
      if (reg_wr) begin
        arm_pg <= wr_page;
        arm_me <= wr_meen;
      end
      if (wr_page) page_q <= reg_wdata[PW-1:0];
      if (wr_meen) meen_q <= reg_wdata[0];
    end
  end

  assign erase_page = page_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == AW'(PAGE_ADDR))      reg_rdata = {{PAD{1'b0}}, page_q};
      else if (reg_addr == AW'(MEEN_ADDR)) reg_rdata = {{(DW-1){1'b0}}, meen_q};
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_erase_start && mass_erase_start)); // R10
  AST_PAGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_start |=> !page_erase_start); // R10
  AST_MASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_start |=> !mass_erase_start); // R10
  AST_PAGE_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_start |-> $past(reg_wr && reg_addr == AW'(CMD_ADDR)
                               && reg_wdata == DW'(PAGE_KEY) && !flash_busy)); // R3
  AST_MASS_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_start |-> $past(reg_wr && reg_addr == AW'(CMD_ADDR)
                               && reg_wdata == DW'(MASS_KEY) && dbg_en && !flash_busy)); // R6
  AST_PAGE_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_start |-> $stable(erase_page)); // R3
  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(CMD_ADDR)) |-> reg_rdata == '0); // R9
  AST_PAGE_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(PAGE_ADDR)) |-> !reg_rdata[DW-1]); // R2

endmodule

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       dbg_en = 1'b0, flash_busy = 1'b0;
  logic       pstart, mstart;
  logic [6:0] epage;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CMD = 8'h94, A_PAGE = 8'hB7, A_MEEN = 8'hB2;

  always #5 clk = ~clk;

  flash_erase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dbg_en(dbg_en), .flash_busy(flash_busy),
    .page_erase_start(pstart), .mass_erase_start(mstart), .erase_page(epage)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 page_start", pstart, 0);
    chk("R1 mass_start", mstart, 0);
    chk("R1 erase_page", epage, 0);
    rst_n = 1'b1;
    rd(A_PAGE, d); chk("R1 page read", d, 0);
    rd(A_MEEN, d); chk("R1 meen read", d, 0);

    // R2 page sweep, R3 page erase with each page
    for (int v = 0; v < 256; v++) begin
      wr(A_PAGE, 8'(v));
      rd(A_PAGE, d); chk("R2 page read", d, v & 8'h7F);
      chk("R2 erase_page", epage, v & 8'h7F);
      wr(A_PAGE, 8'(v));
      wr(A_CMD, 8'h55);
      chk("R3 page pulse", pstart, 1);
      chk("R3 page number", epage, v & 8'h7F);
      chk("R10 no mass", mstart, 0);
      @(negedge clk);
      chk("R10 page pulse width", pstart, 0);
    end

    // R7/R3 sweep of command bytes after page arm
    dbg_en = 1'b1;
    for (int c = 0; c < 256; c++) begin
      wr(A_PAGE, 8'h21);
      wr(A_CMD, 8'(c));
      chk("R7 page key sweep", pstart, (c == 8'h55) ? 1 : 0);
      chk("R10 no mass after page arm", mstart, 0);
      wr(A_CMD, 8'h55);
      chk("R7 arm cleared", pstart, 0);
    end

    // R5/R7 sweep of command bytes after enable arm
    for (int c = 0; c < 256; c++) begin
      wr(A_MEEN, 8'h01);
      wr(A_CMD, 8'(c));
      chk("R5 mass key sweep", mstart, (c == 8'hAA) ? 1 : 0);
      chk("R10 no page after mass arm", pstart, 0);
      @(negedge clk);
      chk("R10 mass pulse width", mstart, 0);
      wr(A_CMD, 8'hAA);
      chk("R7 mass arm cleared", mstart, 0);
    end

    // R6 debug disabled
    dbg_en = 1'b0;
    wr(A_MEEN, 8'h01); wr(A_CMD, 8'hAA);
    chk("R6 dbg low", mstart, 0);
    dbg_en = 1'b1;
    wr(A_PAGE, 8'h05); wr(A_CMD, 8'hAA);
    chk("R6 wrong arm", mstart, 0);

    // R4 no arm and intervening write
    wr(A_CMD, 8'h55); chk("R4 no setup", pstart, 0);
    wr(A_PAGE, 8'h07); wr(8'h10, 8'h00); wr(A_CMD, 8'h55);
    chk("R4 intervening write", pstart, 0);
    wr(A_MEEN, 8'h01); wr(A_CMD, 8'h55);
    chk("R4 wrong arm", pstart, 0);

    // R8 busy
    flash_busy = 1'b1;
    wr(A_PAGE, 8'h09); wr(A_CMD, 8'h55);
    chk("R8 busy page", pstart, 0);
    wr(A_MEEN, 8'h01); wr(A_CMD, 8'hAA);
    chk("R8 busy mass", mstart, 0);
    wr(A_PAGE, 8'h09);
    flash_busy = 1'b1; wr(A_CMD, 8'h55);
    flash_busy = 1'b0; wr(A_CMD, 8'h55);
    chk("R8 busy cleared arm", pstart, 0);

    // R9 reads
    wr(A_CMD, 8'h5A);
    rd(A_CMD, d); chk("R9 cmd read", d, 0);
    wr(A_MEEN, 8'hFF); rd(A_MEEN, d); chk("R9 meen read one", d, 1);
    wr(A_MEEN, 8'hFE); rd(A_MEEN, d); chk("R9 meen read zero", d, 0);
    rd(8'h10, d); chk("R9 unmapped read", d, 0);
    reg_addr = A_PAGE; #1 chk("R9 no strobe read", reg_rdata, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule